// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter placed on a small byte-wide register bus. A 4-bit key field in the control register decides whether it counts. Only the exact code `4'b1010` halts it, and every other code lets it run. The counter advances on each pulse of an external tick input. Software keeps it alive by writing a restart bit before the count reaches a programmable timeout.

When the timeout is reached, the block produces a single-cycle pulse. A mode bit decides whether that pulse goes to the non-maskable interrupt line or to the reset-request line. An interrupt expiry also sets a sticky status flag that software can read. After an expiry the counter goes back to zero and keeps running, so the event repeats if nothing services the block. Turning the reset request into an actual system reset, and vectoring the interrupt, belong to the surrounding chip.

Top module: `kwdog`

## Requirements
- R1: After reset the control register (address 0) reads `0x0A` and the status register (address 1) reads `0x00`. Neither output pulses, so the watchdog starts halted in interrupt mode.
- R2: Bits [3:0] of the control register hold the key. The key is written directly and read back. Any key other than `4'b1010` makes the counter advance by one on each cycle where `tickIn` is high.
- R3: While the key equals `4'b1010`, ticks are ignored and the count is held. When a running key is written again, counting resumes from the held value.
- R4: The tick that brings the count since the last restart or expiry to `TIMEOUT` is the expiring tick. In interrupt mode it produces a `nmiPulse` exactly one clock wide, in the cycle after that tick is sampled.
- R5: When status bit 1 (mode) is 1, expiry pulses `rstReq` instead of `nmiPulse`, and the status flag is left alone. The two outputs are never high together.
- R6: Status bit 0 is a sticky flag. It becomes 1 together with each `nmiPulse`, and writes to bit 0 do not change it.
- R7: Writing control bit 4 as 1 sets the count to zero and clears the status flag. Writing it as 0 restarts nothing. Bit 4 always reads 0.
- R8: Control bits [7:5] and status bits [7:2] always read 0, whatever was written.
- R9: After an expiry the count starts again from zero without any software action, so a further `TIMEOUT` ticks give another expiry.
- R10: A restart write in the same cycle as the expiring tick takes precedence. No pulse is produced, and the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | Count enable pulse, one count per high cycle |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register select: 0 control, 1 status |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| nmiPulse | output | 1 | One-cycle expiry pulse in interrupt mode |
| rstReq | output | 1 | One-cycle expiry pulse in reset mode |

## Verification
The hardest case to reach from the ports is the collision in R10. A restart write has to land on exactly the clock edge where the expiring tick is sampled. The bench gets there by counting `TIMEOUT-1` ticks after a known restart, then driving the tick and the restart write together on the same negative edge. It then confirms that no pulse appears and that a full further `TIMEOUT` ticks are needed. The held count under R3 is also invisible at the ports. It is exposed by halting partway through a period, applying many ticks, resuming, and measuring how many more ticks it takes to reach expiry.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
  localparam logic [3:0] HALT_KEY   = 4'b1010;
  localparam int         RESTART_BIT = 4;
  localparam int         MODE_BIT    = 1;
  localparam int         FLAG_BIT    = 0;
  localparam int         CTRL_ADDR   = 0;
  localparam int         STAT_ADDR   = 1;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic run;
    logic restart;
  } kwdog_strobe_t;
endpackage

// File: rtl/kwdog_dp.sv
module kwdog_dp
  import kwdog_pkg::*;
#(
  parameter int TIMEOUT = 16,
  parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickIn,
  input  kwdog_strobe_t strb,
  output logic          expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cntQ;
  logic             atLast;

  assign atLast = (cntQ == LAST);
  assign expire = strb.run && tickIn && !strb.restart && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.restart) begin
      cntQ <= '0;
    end else if (strb.run && tickIn) begin
      cntQ <= atLast ? '0 : cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/kwdog_ctrl.sv
module kwdog_ctrl
  import kwdog_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              expire,
  output kwdog_strobe_t     strb,
  output logic              nmiPulse,
  output logic              rstReq
);
  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);

  logic [3:0] keyQ;
  logic       modeQ;
  logic       flagQ;
  logic       ctlWr;
  logic       statWr;
  logic       unusedWdata;

  assign ctlWr       = regWe && (regAddr == CTRL_SEL);
  assign statWr      = regWe && (regAddr == STAT_SEL);
  assign unusedWdata = ^regWdata[7:5];

  always_comb begin
    strb.run     = (keyQ != HALT_KEY);
    strb.restart = ctlWr && regWdata[RESTART_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ     <= HALT_KEY;
      modeQ    <= 1'b0;
      flagQ    <= 1'b0;
      nmiPulse <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      if (ctlWr)  keyQ  <= regWdata[3:0];
      if (statWr) modeQ <= regWdata[MODE_BIT];
      if (strb.restart)         flagQ <= 1'b0;
      else if (expire && !modeQ) flagQ <= 1'b1;
      nmiPulse <= expire && !modeQ;
      rstReq   <= expire && modeQ;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_SEL) begin
      regRdata[3:0] = keyQ;
    end else if (regAddr == STAT_SEL) begin
      regRdata[MODE_BIT] = modeQ;
      regRdata[FLAG_BIT] = flagQ;
    end
  end
endmodule

// File: rtl/kwdog.sv
module kwdog
  import kwdog_pkg::*;
#(
  parameter int TIMEOUT = 16,
  parameter int ADDR_W  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              nmiPulse,
  output logic              rstReq
);
  kwdog_strobe_t strb;
  logic          expire;

  kwdog_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .expire(expire),
    .strb(strb), .nmiPulse(nmiPulse), .rstReq(rstReq)
  );

  kwdog_dp #(.TIMEOUT(TIMEOUT)) dp_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .strb(strb), .expire(expire)
  );
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk
  import kwdog_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regRdata,
  input logic              nmiPulse,
  input logic              rstReq,
  input kwdog_strobe_t     strb
);
  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);

  // R4
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPulse || rstReq) |-> $past(tickIn));

  // R5
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nmiPulse && rstReq));

  // R3
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> !(nmiPulse || rstReq));

  // R10
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> !(nmiPulse || rstReq));

  // R6
  flag_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPulse && regAddr == STAT_SEL) |-> regRdata[FLAG_BIT]);

  // R8
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_SEL) |-> (regRdata[7:4] == 4'h0));

  // R8
  stat_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STAT_SEL) |-> (regRdata[7:2] == 6'h00));
endmodule

bind kwdog kwdog_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .regAddr(regAddr),
  .regRdata(regRdata), .nmiPulse(nmiPulse), .rstReq(rstReq), .strb(strb)
);

// File: tb/kwdog_tb_top.sv
`timescale 1ns/1ps
module kwdog_tb_top;
  localparam int TO = 6;

  typedef struct packed {
    logic       a;
    logic [7:0] wd;
    logic [7:0] exp;
  } vec_t;

  // register write / read-back vectors (R2, R6, R7, R8)
  localparam vec_t VEC [6] = '{
    '{1'b0, 8'h05, 8'h05},
    '{1'b0, 8'hFA, 8'h0A},
    '{1'b0, 8'hE3, 8'h03},
    '{1'b1, 8'hFD, 8'h00},
    '{1'b1, 8'h01, 8'h00},
    '{1'b0, 8'h1A, 8'h0A}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       regWe = 1'b0;
  logic [0:0] regAddr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       nmiPulse;
  logic       rstReq;

  int checks = 0;
  int errors = 0;
  int nmiCnt = 0;
  int rstCnt = 0;
  int wideCnt = 0;
  logic prevPulse = 1'b0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  kwdog #(.TIMEOUT(TO), .ADDR_W(1)) dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .nmiPulse(nmiPulse), .rstReq(rstReq)
  );

  always @(negedge clk) begin
    if (nmiPulse) nmiCnt++;
    if (rstReq) rstCnt++;
    if ((nmiPulse || rstReq) && prevPulse) wideCnt++;
    prevPulse = nmiPulse || rstReq;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic a);
    regAddr = a;
    #1;
    rv = regRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    rd(1'b0); chk("R1 control after reset", rv, 8'h0A);
    rd(1'b1); chk("R1 status after reset", rv, 8'h00);
    chk("R1 no pulse after reset", nmiCnt + rstCnt, 0);

    ticks(3 * TO); settle();
    chk("R3 halted at reset ignores ticks", nmiCnt + rstCnt, 0);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i].a, VEC[i].wd);
      rd(VEC[i].a);
      chk("R2/R8 register vector", rv, VEC[i].exp);
    end

    wr(1'b0, 8'h05);
    ticks(TO - 1); settle();
    chk("R2 no expiry before timeout", nmiCnt, 0);
    ticks(1); settle();
    chk("R4 nmi at timeout", nmiCnt, 1);
    chk("R5 no reset request in nmi mode", rstCnt, 0);
    rd(1'b1); chk("R6 flag set after nmi", rv, 8'h01);
    wr(1'b1, 8'h01);
    rd(1'b1); chk("R6 flag ignores writes", rv, 8'h01);

    ticks(TO); settle();
    chk("R9 repeat expiry after wrap", nmiCnt, 2);

    wr(1'b0, 8'h15);
    rd(1'b1); chk("R7 restart clears flag", rv, 8'h00);
    rd(1'b0); chk("R7 restart bit reads zero", rv, 8'h05);
    ticks(TO - 2);
    wr(1'b0, 8'h15);
    ticks(TO - 1); settle();
    chk("R7 restart resets count", nmiCnt, 2);
    ticks(1); settle();
    chk("R7 expiry after restart", nmiCnt, 3);

    ticks(3);
    wr(1'b0, 8'h05);
    ticks(TO - 3); settle();
    chk("R7 zero restart bit no effect", nmiCnt, 4);
    rd(1'b1); chk("R7 flag kept without restart", rv, 8'h01);

    wr(1'b0, 8'h15);
    ticks(2);
    wr(1'b0, 8'h0A);
    ticks(10); settle();
    chk("R3 halted holds", nmiCnt, 4);
    wr(1'b0, 8'h0F);
    ticks(TO - 3); settle();
    chk("R3 held count resumes", nmiCnt, 4);
    ticks(1); settle();
    chk("R3 expiry after resume", nmiCnt, 5);

    wr(1'b1, 8'h02);
    wr(1'b0, 8'h15);
    rd(1'b1); chk("R5 mode readback", rv, 8'h02);
    ticks(TO); settle();
    chk("R5 reset request in reset mode", rstCnt, 1);
    chk("R5 no nmi in reset mode", nmiCnt, 5);
    rd(1'b1); chk("R5 flag untouched", rv, 8'h02);

    wr(1'b1, 8'h00);
    wr(1'b0, 8'h15);
    ticks(TO - 1);
    @(negedge clk);
    tickIn = 1'b1; regWe = 1'b1; regAddr = 1'b0; regWdata = 8'h15;
    @(negedge clk);
    tickIn = 1'b0; regWe = 1'b0;
    settle();
    chk("R10 collision gives no pulse", nmiCnt + rstCnt, 6);
    ticks(TO - 1); settle();
    chk("R10 count from zero after collision", nmiCnt, 5);
    ticks(1); settle();
    chk("R10 expiry after full period", nmiCnt, 6);

    chk("R4 pulses one cycle wide", wideCnt, 0);
    finishRun();
  end
endmodule